// File: doc/BRIEF.md
# Pseudorandom Down-Spread Modulation Code Generator

This block produces the digital code that steers a down-spread clock modulator. A 9-bit maximal-length shift register advances once per 3200 cycles of the master clock. After each advance, its seven least significant bits are presented in parallel as a 128-level code. A converter downstream, either a multiplying DAC or a digital frequency scaler, turns that code into a frequency reduction. A code of zero means no reduction, so the output runs at the full, unmodulated frequency. A larger code only ever lowers the frequency.

A single enable input marks whether modulation is active. While enable is low, the prescaler is parked at zero and the shift register keeps its state. The code is forced to zero, so the downstream logic sees the maximum frequency. When enable returns, the prescaler counts a full interval from zero before the next step. The pseudorandom sequence then resumes where it stopped. A one-cycle strobe marks every cycle in which a fresh code is presented.

Top module: `spread_code_gen`

## Requirements
- R1: Synchronous reset (active high) loads the shift register with the seed 9'h1FF and drives the code to 0 and the strobe to 0.
- R2: While enable is high, the strobe is high for exactly one cycle once every 3200 enabled clock edges, counted from the reset release or from the last edge at which enable was low.
- R3: On each step the 9-bit state s (bit 8 = most significant) advances by the recurrence of x^9 + x^5 + 1: the next state is {s[7:0], s[8] XOR s[4]}.
- R4: In the cycle the strobe is high, the code equals bits 6 down to 0 of the new state, with code bit i taken from state bit i.
- R5: While enable stays high, the code does not change between strobes.
- R6: One cycle after an edge at which enable is low, the code reads 0 and the strobe is low. The prescaler restarts from zero, and the shift register keeps its state, so the sequence continues unbroken after re-enable.
- R7: After enable returns high, the code stays 0 until the first strobe, which arrives 3200 enabled edges later.
- R8: The shift register never holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| modEn | input | 1 | Modulation active; low parks the block and zeroes the code |
| modCode | output | 7 | Down-spread code; 0 means full frequency |
| stepStrobe | output | 1 | One-cycle pulse when a new code is presented |

## Verification
The strobe and the new code both come from registers. They become visible right after the 3200th enabled edge, in the same cycle, and the zeroed code appears right after the first edge with enable low. The inputs are driven just after the falling edge. The bench compares the outputs at the next falling edge against a count of enabled edges kept in the bench. A strobe is accepted only when that count reaches exactly 3200. The code popped from the scoreboard queue must match it in that same cycle. In every other enabled cycle, the code must equal the value seen one cycle earlier.

// File: rtl/spread_code_pkg.sv
package spread_code_pkg;

  // Strobes from the prescaler control to the shift-register datapath.
  typedef struct packed {
    logic advance;  // step the shift register this edge
    logic blank;    // modulation inactive: force the code to zero
  } stepCtl_t;

endpackage

// File: rtl/spread_step_ctrl.sv
module spread_step_ctrl
  import spread_code_pkg::*;
#(
  parameter int STEP_DIV = 3200
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     modEn,
  output stepCtl_t ctl
);

  localparam int CNT_W = $clog2(STEP_DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);

  logic [CNT_W-1:0] cntQ;
  logic             tick;

  assign tick = modEn && (cntQ == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
    end else if (!modEn || tick) begin
      cntQ <= '0;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_comb begin
    ctl.advance = tick;
    ctl.blank   = !modEn;
  end

  // R2: the prescaler never leaves its range
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cntQ <= LAST);

  // R6: a low enable parks the prescaler at zero
  assert_park_R6: assert property (@(posedge clk) disable iff (rst)
    !modEn |=> cntQ == '0);

endmodule

// File: rtl/spread_lfsr_dp.sv
module spread_lfsr_dp
  import spread_code_pkg::*;
#(
  parameter int          LFSR_W = 9,
  parameter int          TAP    = 5,
  parameter int          CODE_W = 7,
  parameter logic [LFSR_W-1:0] SEED = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst,
  input  stepCtl_t          ctl,
  output logic [CODE_W-1:0] modCode,
  output logic              stepStrobe
);

  logic [LFSR_W-1:0] stateQ;
  logic [LFSR_W-1:0] shifted;
  logic [LFSR_W-1:0] safeNext;
  logic              feedback;
  logic [CODE_W-1:0] codeQ;
  logic              strobeQ;

  assign feedback = stateQ[LFSR_W-1] ^ stateQ[TAP-1];

  assign shifted[0] = feedback;
  for (genvar i = 1; i < LFSR_W; i++) begin : g_shift
    assign shifted[i] = stateQ[i-1];
  end

  // Guard against the lock-up state; unreachable from a nonzero seed.
  assign safeNext = (shifted == '0) ? SEED : shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= SEED;
      codeQ   <= '0;
      strobeQ <= 1'b0;
    end else begin
      strobeQ <= ctl.advance;
      if (ctl.blank) begin
        codeQ <= '0;
      end else if (ctl.advance) begin
        stateQ <= safeNext;
        codeQ  <= safeNext[CODE_W-1:0];
      end
    end
  end

  assign modCode    = codeQ;
  assign stepStrobe = strobeQ;

  // R8: never the all-zero state
  assert_no_lockup_R8: assert property (@(posedge clk) disable iff (rst)
    stateQ != '0);

  // R3: a step shifts the state up by one place
  assert_step_shift_R3: assert property (@(posedge clk) disable iff (rst)
    ctl.advance |=> stateQ[LFSR_W-1:1] == $past(stateQ[LFSR_W-2:0]));

  // R2: the strobe lasts a single cycle
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    stepStrobe |=> !stepStrobe);

  // R5: no step, no code change while enabled
  assert_code_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctl.blank && !ctl.advance) |=> modCode == $past(modCode));

  // R6: disabled edge yields zero code and no strobe
  assert_off_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.blank |=> (modCode == '0) && !stepStrobe);

endmodule

// File: rtl/spread_code_gen.sv
module spread_code_gen
  import spread_code_pkg::*;
#(
  parameter int STEP_DIV = 3200,
  parameter int LFSR_W   = 9,
  parameter int TAP      = 5,
  parameter int CODE_W   = 7,
  parameter logic [LFSR_W-1:0] SEED = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modEn,
  output logic [CODE_W-1:0] modCode,
  output logic              stepStrobe
);

  stepCtl_t ctl;

  spread_step_ctrl #(
    .STEP_DIV(STEP_DIV)
  ) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .modEn(modEn),
    .ctl  (ctl)
  );

  spread_lfsr_dp #(
    .LFSR_W(LFSR_W),
    .TAP   (TAP),
    .CODE_W(CODE_W),
    .SEED  (SEED)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .modCode   (modCode),
    .stepStrobe(stepStrobe)
  );

endmodule

// File: tb/spread_code_gen_test.sv
`timescale 1ns/1ps
module spread_code_gen_test;

  localparam int DIV = 3200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modEn = 1'b0;
  logic [6:0] modCode;
  logic       stepStrobe;

  int testsRun = 0;
  int testsFailed = 0;
  int enCount = 0;
  int stepsSeen = 0;
  logic [6:0] lastCode = '0;
  logic [6:0] expQ[$];

  always #10 clk = ~clk;

  spread_code_gen uut (
    .clk(clk), .rst(rst), .modEn(modEn),
    .modCode(modCode), .stepStrobe(stepStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver side of the scoreboard: queue the codes that follow the seed (R3, R4).
  task automatic loadExpected(input int n);
    logic [8:0] s = 9'h1FF;
    expQ.delete();
    for (int k = 0; k < n; k++) begin
      s = {s[7:0], s[8] ^ s[4]};
      expQ.push_back(s[6:0]);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Monitor: inputs change 1 ns after a falling edge, so here they equal
  // the values sampled at the rising edge just passed.
  always @(negedge clk) begin
    if (rst) begin
      enCount = 0;
    end else if (!modEn) begin
      check(modCode == 0 && !stepStrobe, "R6 zero code while disabled", modCode, 0);
      enCount = 0;
    end else begin
      enCount++;
      if (stepStrobe) begin
        stepsSeen++;
        check(enCount == DIV, "R2 step interval", enCount, DIV);
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected step", modCode, -1);
        end else begin
          logic [6:0] e;
          e = expQ.pop_front();
          check(modCode == e, "R3/R4 step code", modCode, e);
        end
        enCount = 0;
      end else begin
        check(enCount < DIV, "R2 missing step", enCount, DIV);
        check(modCode == lastCode, "R5 code hold", modCode, lastCode);
      end
    end
    lastCode = modCode;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    loadExpected(40);
    cycles(3);
    check(modCode == 0, "R1 reset code", modCode, 0);
    check(stepStrobe == 0, "R1 reset strobe", stepStrobe, 0);
    rst = 1'b0;
    cycles(5);
    check(modCode == 0 && !stepStrobe, "R6 idle after reset", modCode, 0);
    modEn = 1'b1;
    cycles(6 * DIV);
    cycles(1000);
    // Disable mid-interval: prescaler restarts, state held (R6).
    modEn = 1'b0;
    cycles(1);
    check(modCode == 0, "R6 zero one cycle after disable", modCode, 0);
    cycles(500);
    modEn = 1'b1;
    cycles(10);
    check(modCode == 0, "R7 zero before first step after re-enable", modCode, 0);
    cycles(4 * DIV + 100);
    check(stepsSeen == 10, "R2 steps before reset", stepsSeen, 10);
    // Reset mid-run reloads the seed (R1).
    rst = 1'b1;
    cycles(2);
    check(modCode == 0 && !stepStrobe, "R1 reset mid-run", modCode, 0);
    loadExpected(40);
    rst = 1'b0;
    cycles(2 * DIV + 10);
    check(stepsSeen == 12, "R2 total steps", stepsSeen, 12);
    check(expQ.size() == 38, "R3 codes consumed after reset", expQ.size(), 38);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule